// File: doc/BRIEF.md
# Gated Interrupt Request Latch Register

This block is an 8-bit software-visible register that holds six pending interrupt requests. Each request line sets its own flag, and a per-bit acknowledge clears a flag once the controller has serviced it. Software reaches the register through a small register-file style port: an 8-bit address, a write enable with write data, and a combinational read data output.

After power-on the register is inert. It reads as zero and ignores request lines, acknowledges and software writes. It becomes active only when an enable-interrupts strobe is seen, and it then stays active until the next power-on reset. A disable-interrupts strobe leaves it untouched. This arming step is needed even by code that only polls the flags. A write to any other address, including a mask register location with its global-enable bit set, cannot arm it.

The arming control is a two-state machine. `ST_DISARMED` is entered on reset. The transition `T_ARM`, taken on an enable strobe, leads to `ST_ARMED`. From `ST_ARMED` the self-transition `T_HOLD` is taken on every cycle, with or without a disable strobe. `ST_DISARMED` has the self-transition `T_WAIT` for every cycle without an enable strobe.

Top module: `intreq_latch`

## Requirements
- R1: While `por_n` is low the register reads 00h and the block is disarmed. It is disarmed again after every reset.
- R2: While disarmed, request pulses, acknowledges and writes to address FAh leave the register at 00h, and a read of FAh returns 00h.
- R3: An `ei_stb` pulse arms the block at that clock edge. Inputs in the same cycle as the pulse are ignored, and inputs from the following cycle on take effect. A write to any other address, such as FBh with bit 7 set, does not arm the block.
- R4: While armed, a pulse on `req_i[n]` (n = 0..5) sets register bit n at the next edge. A request held high sets its bit again on every cycle.
- R5: While armed, a write with `wr_en` high at address FAh stores all eight data bits at the next edge. `rd_data` shows the register in the same cycle that `acc_addr` is FAh.
- R6: If a request and a write that clears the same bit fall in the same cycle, the bit ends at 1.
- R7: While armed, `ack_i[n]` clears bit n at the next edge. A request in the same cycle keeps the bit at 1. A write in the same cycle decides the bit's value.
- R8: Bits 7 and 6 are plain storage. Only a write at FAh while armed changes them. Requests and acknowledges never change them.
- R9: `di_stb` has no effect on the arming or the contents. A second `ei_stb` has no effect. The armed state lasts until the next reset.
- R10: A write to any address other than FAh changes nothing, and a read of any other address returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| req_i | input | 6 | Synchronous request pulses, one per source |
| ack_i | input | 6 | Per-bit service acknowledge |
| ei_stb | input | 1 | Enable-interrupts execution strobe |
| di_stb | input | 1 | Disable-interrupts execution strobe |
| acc_addr | input | 8 | Register access address |
| wr_en | input | 1 | Write enable |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data; 00h unless the address is FAh |

## Verification
Every change to the register or to the arming is due at the first rising edge after the stimulus, because each passes through exactly one flop. The read path has no register, so `rd_data` is due in the same cycle that the address is presented. The bench drives each stimulus on a falling edge and holds it for one full cycle. It then sets the address to FAh and compares `rd_data` just after the next falling edge, so exactly one rising edge separates the stimulus from the sample. The address sweep changes only `acc_addr` and samples within that same cycle.

// File: rtl/intreq_pkg.sv
package intreq_pkg;
    localparam int unsigned REG_W_D    = 8;
    localparam int unsigned REQ_W_D    = 6;
    localparam int unsigned ADDR_W_D   = 8;
    localparam logic [7:0]  REG_ADDR_D = 8'hFA;

    typedef enum logic [0:0] {
        ST_DISARMED = 1'b0,
        ST_ARMED    = 1'b1
    } arm_state_t;
endpackage

// File: rtl/intreq_arm_fsm.sv
module intreq_arm_fsm
    import intreq_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic ei_stb,
    input  logic di_stb,
    output logic armed
);
    arm_state_t state_q;
    arm_state_t state_d;

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_DISARMED;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: T_WAIT, T_ARM, T_HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DISARMED: begin
                if (ei_stb) begin
                    state_d = ST_ARMED;      // T_ARM
                end else begin
                    state_d = ST_DISARMED;   // T_WAIT
                end
            end
            ST_ARMED: begin
                if (di_stb) begin
                    state_d = ST_ARMED;      // T_HOLD, disable strobe leaves arming alone
                end else begin
                    state_d = ST_ARMED;      // T_HOLD
                end
            end
            default: state_d = ST_DISARMED;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_ARMED:    armed = 1'b1;
            ST_DISARMED: armed = 1'b0;
            default:     armed = 1'b0;
        endcase
    end
endmodule

// File: rtl/intreq_bit_cell.sv
module intreq_bit_cell (
    input  logic clk,
    input  logic por_n,
    input  logic armed,
    input  logic req,
    input  logic ack,
    input  logic wr_hit,
    input  logic wr_bit,
    output logic q
);
    // priority while armed: request, then write, then acknowledge
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            q <= 1'b0;
        end else if (armed) begin
            if (req) begin
                q <= 1'b1;
            end else if (wr_hit) begin
                q <= wr_bit;
            end else if (ack) begin
                q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/intreq_bus_port.sv
module intreq_bus_port #(
    parameter int unsigned       ADDR_W   = 8,
    parameter int unsigned       REG_W    = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'hFA
) (
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  reg_q,
    output logic              wr_hit,
    output logic [REG_W-1:0]  rd_data
);
    logic sel;

    always_comb begin
        sel     = (acc_addr == REG_ADDR);
        wr_hit  = sel && wr_en;
        rd_data = sel ? reg_q : '0;
    end
endmodule

// File: rtl/intreq_latch.sv
module intreq_latch
    import intreq_pkg::*;
#(
    parameter int unsigned       REG_W    = REG_W_D,
    parameter int unsigned       REQ_W    = REQ_W_D,
    parameter int unsigned       ADDR_W   = ADDR_W_D,
    parameter logic [ADDR_W-1:0] REG_ADDR = REG_ADDR_D
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic [REQ_W-1:0]  req_i,
    input  logic [REQ_W-1:0]  ack_i,
    input  logic              ei_stb,
    input  logic              di_stb,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data
);
    logic             armed;
    logic             wr_hit;
    logic [REG_W-1:0] reg_q;

    intreq_arm_fsm u_fsm (
        .clk    (clk),
        .por_n  (por_n),
        .ei_stb (ei_stb),
        .di_stb (di_stb),
        .armed  (armed)
    );

    intreq_bus_port #(
        .ADDR_W   (ADDR_W),
        .REG_W    (REG_W),
        .REG_ADDR (REG_ADDR)
    ) u_port (
        .acc_addr (acc_addr),
        .wr_en    (wr_en),
        .reg_q    (reg_q),
        .wr_hit   (wr_hit),
        .rd_data  (rd_data)
    );

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (i < REQ_W) begin : g_req
            intreq_bit_cell u_cell (
                .clk    (clk),
                .por_n  (por_n),
                .armed  (armed),
                .req    (req_i[i]),
                .ack    (ack_i[i]),
                .wr_hit (wr_hit),
                .wr_bit (wr_data[i]),
                .q      (reg_q[i])
            );
        end else begin : g_plain
            intreq_bit_cell u_cell (
                .clk    (clk),
                .por_n  (por_n),
                .armed  (armed),
                .req    (1'b0),
                .ack    (1'b0),
                .wr_hit (wr_hit),
                .wr_bit (wr_data[i]),
                .q      (reg_q[i])
            );
        end
    end
endmodule

// File: rtl/intreq_latch_chk.sv
module intreq_latch_chk #(
    parameter int unsigned       REG_W    = 8,
    parameter int unsigned       REQ_W    = 6,
    parameter int unsigned       ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'hFA
) (
    input logic              clk,
    input logic              por_n,
    input logic [REQ_W-1:0]  req_i,
    input logic [REQ_W-1:0]  ack_i,
    input logic              ei_stb,
    input logic              di_stb,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              wr_en,
    input logic [REG_W-1:0]  wr_data,
    input logic [REG_W-1:0]  rd_data,
    input logic              armed,
    input logic [REG_W-1:0]  reg_q
);
    logic hit;
    assign hit = wr_en && (acc_addr == REG_ADDR);

    assert_disarmed_clear_R2: assert property (@(posedge clk) disable iff (!por_n)
        !armed |-> (reg_q == '0));

    assert_arm_on_ei_R3: assert property (@(posedge clk) disable iff (!por_n)
        (!armed && ei_stb) |=> armed);

    assert_stay_disarmed_R3: assert property (@(posedge clk) disable iff (!por_n)
        (!armed && !ei_stb) |=> !armed);

    assert_armed_sticky_R9: assert property (@(posedge clk) disable iff (!por_n)
        (armed || di_stb) && armed |=> armed);

    assert_req_sets_R4: assert property (@(posedge clk) disable iff (!por_n)
        armed |=> ((reg_q[REQ_W-1:0] & $past(req_i)) == $past(req_i)));

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!por_n)
        (armed && !hit) |=> ((reg_q[REQ_W-1:0] & $past(ack_i & ~req_i)) == '0));

    assert_write_stores_R5: assert property (@(posedge clk) disable iff (!por_n)
        (armed && hit) |=> (reg_q[REG_W-1:REQ_W] == $past(wr_data[REG_W-1:REQ_W])));

    assert_upper_hold_R8: assert property (@(posedge clk) disable iff (!por_n)
        !(armed && hit) |=> $stable(reg_q[REG_W-1:REQ_W]));

    assert_read_zero_R10: assert property (@(posedge clk) disable iff (!por_n)
        (acc_addr != REG_ADDR) |-> (rd_data == '0));
endmodule

bind intreq_latch intreq_latch_chk #(
    .REG_W    (REG_W),
    .REQ_W    (REQ_W),
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR)
) u_chk (
    .clk      (clk),
    .por_n    (por_n),
    .req_i    (req_i),
    .ack_i    (ack_i),
    .ei_stb   (ei_stb),
    .di_stb   (di_stb),
    .acc_addr (acc_addr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .armed    (armed),
    .reg_q    (reg_q)
);

// File: tb/test_intreq_latch.sv
module test_intreq_latch;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [7:0] REG_A = 8'hFA;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic [5:0] req = '0;
    logic [5:0] ack = '0;
    logic       ei = 1'b0;
    logic       di = 1'b0;
    logic [7:0] addr = REG_A;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intreq_latch i_intreq_latch (
        .clk      (clk),
        .por_n    (por_n),
        .req_i    (req),
        .ack_i    (ack),
        .ei_stb   (ei),
        .di_stb   (di),
        .acc_addr (addr),
        .wr_en    (wr),
        .wr_data  (wdata),
        .rd_data  (rd_data)
    );

    task automatic chk(input logic [7:0] exp, input string tag);
        checks++;
        if (rd_data !== exp) begin
            fails++;
            $display("FAIL %s: rd_data=%h expected %h", tag, rd_data, exp);
        end
    endtask

    // one stimulus cycle, then idle with address FAh and sample after the edge
    task automatic drive(input logic [5:0] rq, input logic [5:0] ak, input logic e,
                         input logic d, input logic w, input logic [7:0] a,
                         input logic [7:0] dt);
        @(negedge clk);
        req = rq; ack = ak; ei = e; di = d; wr = w; addr = a; wdata = dt;
        @(negedge clk);
        req = '0; ack = '0; ei = 1'b0; di = 1'b0; wr = 1'b0; addr = REG_A; wdata = '0;
        #1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete");
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        #1 chk(8'h00, "R1 in reset");
        @(negedge clk);
        por_n = 1'b1;
        #1 chk(8'h00, "R1 after release");

        // R2: disarmed ignores everything
        for (int p = 1; p < 64; p++) begin
            drive(p[5:0], 6'h00, 1'b0, 1'b0, 1'b0, REG_A, 8'h00);
            chk(8'h00, "R2 request while disarmed");
        end
        for (int d = 0; d < 256; d++) begin
            drive(6'h00, 6'h3F, 1'b0, 1'b0, 1'b1, REG_A, d[7:0]);
            chk(8'h00, "R2 write while disarmed");
        end

        // R3: mask-style write does not arm; disable strobe does not arm
        drive(6'h00, 6'h00, 1'b0, 1'b0, 1'b1, 8'hFB, 8'h80);
        drive(6'h01, 6'h00, 1'b0, 1'b1, 1'b0, REG_A, 8'h00);
        chk(8'h00, "R3 no arm from other address or disable");
        drive(6'h00, 6'h00, 1'b0, 1'b0, 1'b1, REG_A, 8'hC3);
        chk(8'h00, "R3 still disarmed");
        // arming cycle ignores its own request
        drive(6'h3F, 6'h00, 1'b1, 1'b0, 1'b0, REG_A, 8'h00);
        chk(8'h00, "R3 request in arming cycle ignored");
        drive(6'h01, 6'h00, 1'b0, 1'b0, 1'b0, REG_A, 8'h00);
        chk(8'h01, "R3 request after arming");

        // R5: full write sweep
        for (int d = 0; d < 256; d++) begin
            drive(6'h00, 6'h00, 1'b0, 1'b0, 1'b1, REG_A, d[7:0]);
            chk(d[7:0], "R5 write");
        end

        // R10: read and write at other addresses
        for (int a = 0; a < 256; a++) begin
            @(negedge clk);
            addr = a[7:0];
            #1 chk((a == 32'hFA) ? 8'hFF : 8'h00, "R10 read decode");
        end
        drive(6'h00, 6'h00, 1'b0, 1'b0, 1'b1, 8'hFB, 8'h00);
        chk(8'hFF, "R10 write elsewhere FB");
        drive(6'h00, 6'h00, 1'b0, 1'b0, 1'b1, 8'h7A, 8'h00);
        chk(8'hFF, "R10 write elsewhere 7A");

        // R4 / R8: request sweep, upper bits untouched
        for (int p = 0; p < 64; p++) begin
            drive(6'h00, 6'h00, 1'b0, 1'b0, 1'b1, REG_A, 8'h00);
            drive(p[5:0], 6'h00, 1'b0, 1'b0, 1'b0, REG_A, 8'h00);
            chk({2'b00, p[5:0]}, "R4 R8 request sets bits");
        end

        // R4: held request re-sets each cycle against clearing writes
        @(negedge clk);
        req = 6'h05; wr = 1'b1; addr = REG_A; wdata = 8'h00;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            #1 chk(8'h05, "R4 held request");
        end
        req = '0; wr = 1'b0;

        // R6: request beats clearing write
        for (int p = 0; p < 64; p++) begin
            drive(p[5:0], 6'h00, 1'b0, 1'b0, 1'b1, REG_A, 8'h00);
            chk({2'b00, p[5:0]}, "R6 request vs write");
        end

        // R7 / R8: acknowledge sweeps
        for (int k = 0; k < 64; k++) begin
            drive(6'h00, 6'h00, 1'b0, 1'b0, 1'b1, REG_A, 8'hFF);
            drive(6'h00, k[5:0], 1'b0, 1'b0, 1'b0, REG_A, 8'h00);
            chk(8'hFF & ~{2'b00, k[5:0]}, "R7 R8 ack clears");
            drive(6'h00, 6'h00, 1'b0, 1'b0, 1'b1, REG_A, 8'h3F);
            drive(k[5:0], 6'h3F, 1'b0, 1'b0, 1'b0, REG_A, 8'h00);
            chk({2'b00, k[5:0]}, "R7 request beats ack");
            drive(6'h00, 6'h3F, 1'b0, 1'b0, 1'b1, REG_A, {2'b01, k[5:0]});
            chk({2'b01, k[5:0]}, "R7 write beats ack");
        end

        // R9: disable strobe and second enable have no effect
        drive(6'h00, 6'h00, 1'b0, 1'b0, 1'b1, REG_A, 8'hA5);
        drive(6'h00, 6'h00, 1'b0, 1'b1, 1'b0, REG_A, 8'h00);
        chk(8'hA5, "R9 disable keeps contents");
        drive(6'h00, 6'h00, 1'b1, 1'b0, 1'b0, REG_A, 8'h00);
        chk(8'hA5, "R9 second enable");
        drive(6'h02, 6'h00, 1'b0, 1'b0, 1'b0, REG_A, 8'h00);
        chk(8'hA7, "R9 still armed after disable");

        // R1: reset disarms again
        @(negedge clk);
        por_n = 1'b0;
        #1 chk(8'h00, "R1 second reset");
        @(negedge clk);
        por_n = 1'b1;
        drive(6'h01, 6'h00, 1'b0, 1'b0, 1'b1, REG_A, 8'hFF);
        chk(8'h00, "R1 disarmed after reset");

        done = 1'b1;
        finish_run();
    end
endmodule